// File: doc/BRIEF.md
# Saturating Rounding Narrowing Shifter

This block narrows every lane of a wide vector to half its width. A source vector is split into lanes of 16, 32 or 64 bits. Each lane is shifted right by a common amount, with optional rounding. The result is then cut or clamped to the half-width destination lane, under one of four result policies. The narrowed lanes are packed into one half of the output vector. The other half is either zeroed or copied from the previous destination vector. Calling the block twice, once for each half, fills a whole register from two sources.

Each operation is presented for one cycle with `op_valid`. The result and `res_valid` appear on the next clock edge. Whenever any lane is clamped, a sticky saturation flag is set. It stays set until reset or until `sat_clr` is applied.

Top module: `nsh_narrow`

## Requirements
- R1: `size` 0 narrows 16-bit lanes to 8 bits, 1 narrows 32 to 16, and 2 narrows 64 to 32. Source lane i, at bits [i*S +: S], produces packed result lane i at bits [i*S/2 +: S/2].
- R2: `size` 3 produces an all-zero packed result and never sets the saturation flag.
- R3: The effective shift is `shamt` limited to the destination lane width, so amounts above the width act as the width. When `noshift` is 1 the effective shift is 0 and `shamt` is ignored.
- R4: When `round_en` is 1 and the effective shift N is not 0, 2^(N-1) is added before the shift. The sum is formed at source width plus two bits, so it never wraps. When N is 0, rounding has no effect.
- R5: `policy` 0 (truncate) keeps the low destination-width bits of the shifted value and never sets the flag.
- R6: `policy` 1 treats the source as signed and clamps the result to the signed destination range.
- R7: `policy` 2 treats the source as unsigned and clamps the result to [0, 2^w-1].
- R8: `policy` 3 treats the source as signed and clamps the result to [0, 2^w-1]. Negative values give 0.
- R9: With `upper_half` set to 0, the packed result goes to bits 63:0 and bits 127:64 are zero.
- R10: With `upper_half` set to 1, the packed result goes to bits 127:64 and bits 63:0 are copied from `dst_old`.
- R11: `sat_flag` becomes 1 after any operation in which a lane clamps. `sat_clr` or reset clears it. If a clear and a clamping operation occur in the same cycle, the flag stays 1.
- R12: `result` and `res_valid` update one cycle after `op_valid`. `result` holds its value while no operation is issued. After reset, all outputs are 0.
- R13: With 16-to-8 narrowing, truncation and a shift of 4, each result byte holds the high nibble of the even source byte in its low nibble and the low nibble of the odd source byte in its high nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Issues an operation this cycle |
| src | input | VEC_W | Source vector of wide lanes |
| dst_old | input | VEC_W | Previous destination, used for the half that is kept |
| shamt | input | SHW (6) | Right shift amount |
| size | input | 2 | Source lane size code |
| noshift | input | 1 | Forces a shift of zero |
| round_en | input | 1 | Enables rounding |
| policy | input | 2 | 0 truncate, 1 signed clamp, 2 unsigned clamp, 3 signed-to-unsigned clamp |
| upper_half | input | 1 | Selects the high half as the target |
| sat_clr | input | 1 | Clears the sticky flag |
| res_valid | output | 1 | Result register was loaded on the last edge |
| result | output | VEC_W | Narrowed vector |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The bench builds the block with its default parameters. These are a 128-bit vector, a 16-bit base lane and three lane sizes, giving 8, 4 and 2 lanes. A 6-bit shift field can therefore express amounts beyond the 32-bit destination width, which exercises the clamping of the shift amount. All three lane sizes and the unused fourth size code can be reached. Because the widest lane is 64 bits, the rounding carry out of an all-ones source must survive at 66 bits for the unsigned clamp to be correct.

// File: rtl/nsh_pkg.sv
package nsh_pkg;

   typedef enum logic [1:0] {
      POL_TRUNC = 2'd0,
      POL_SSAT  = 2'd1,
      POL_USAT  = 2'd2,
      POL_S2U   = 2'd3
   } nsh_pol_e;

   localparam int SIZE_CODE_W = 2;

endpackage

// File: rtl/nsh_lane.sv
module nsh_lane
   import nsh_pkg::*;
#(
   parameter int SRC_W = 16,
   parameter int SHW   = 6,
   localparam int DST_W = SRC_W / 2,
   localparam int W     = SRC_W + 2
) (
   input  logic [SRC_W-1:0] src_i,
   input  logic [SHW-1:0]   n_i,
   input  logic             nosh_i,
   input  logic             rnd_i,
   input  nsh_pol_e         pol_i,
   output logic [DST_W-1:0] dst_o,
   output logic             sat_o
);

   localparam logic signed [W-1:0] SMAX = {{(W-DST_W+1){1'b0}}, {(DST_W-1){1'b1}}};
   localparam logic signed [W-1:0] SMIN = {{(W-DST_W+1){1'b1}}, {(DST_W-1){1'b0}}};
   localparam logic signed [W-1:0] UMAX = {{(W-DST_W){1'b0}}, {DST_W{1'b1}}};

   logic                  sx;
   logic [SHW-1:0]        n_eff;
   logic signed [W-1:0]   ext, addend, sum, shv;

   always_comb begin
      sx  = (pol_i != POL_USAT) & src_i[SRC_W-1];
      ext = {{2{sx}}, src_i};
      if (nosh_i)                    n_eff = '0;
      else if (n_i > SHW'(DST_W))    n_eff = SHW'(DST_W);
      else                           n_eff = n_i;
      addend = '0;
      if (rnd_i && (n_eff != '0)) addend = W'(1) << (n_eff - SHW'(1));
      sum = ext + addend;
      shv = sum >>> n_eff;
      dst_o = shv[DST_W-1:0];
      sat_o = 1'b0;
      case (pol_i)
         POL_SSAT: begin
            if (shv > SMAX)      begin dst_o = SMAX[DST_W-1:0]; sat_o = 1'b1; end
            else if (shv < SMIN) begin dst_o = SMIN[DST_W-1:0]; sat_o = 1'b1; end
         end
         POL_USAT: begin
            if (shv > UMAX)      begin dst_o = UMAX[DST_W-1:0]; sat_o = 1'b1; end
         end
         POL_S2U: begin
            if (shv < 0)         begin dst_o = '0;              sat_o = 1'b1; end
            else if (shv > UMAX) begin dst_o = UMAX[DST_W-1:0]; sat_o = 1'b1; end
         end
         default: ;
      endcase
   end

   // R5: truncation never reports a clamp
   always_comb begin
      if (pol_i == POL_TRUNC) begin
         a_r5_trunc_no_sat: assert (!sat_o);
      end
   end

endmodule

// File: rtl/nsh_slice.sv
module nsh_slice
   import nsh_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int SRC_W = 16,
   parameter int SHW   = 6,
   localparam int LANES = VEC_W / SRC_W,
   localparam int DST_W = SRC_W / 2,
   localparam int HALF_W = VEC_W / 2
) (
   input  logic [VEC_W-1:0]  src_i,
   input  logic [SHW-1:0]    n_i,
   input  logic              nosh_i,
   input  logic              rnd_i,
   input  nsh_pol_e          pol_i,
   output logic [HALF_W-1:0] packed_o,
   output logic              sat_o
);

   logic [LANES-1:0] lane_sat;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      nsh_lane #(.SRC_W(SRC_W), .SHW(SHW)) u_lane (
         .src_i (src_i[i*SRC_W +: SRC_W]),
         .n_i   (n_i),
         .nosh_i(nosh_i),
         .rnd_i (rnd_i),
         .pol_i (pol_i),
         .dst_o (packed_o[i*DST_W +: DST_W]),
         .sat_o (lane_sat[i])
      );
   end

   assign sat_o = |lane_sat;

endmodule

// File: rtl/nsh_narrow.sv
module nsh_narrow
   import nsh_pkg::*;
#(
   parameter int VEC_W      = 128,
   parameter int BASE_SRC_W = 16,
   parameter int NUM_SIZES  = 3,
   localparam int HALF_W  = VEC_W / 2,
   localparam int MAX_SRC = BASE_SRC_W << (NUM_SIZES - 1),
   localparam int MAX_DST = MAX_SRC / 2,
   localparam int SHW     = $clog2(MAX_DST + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   op_valid,
   input  logic [VEC_W-1:0]       src,
   input  logic [VEC_W-1:0]       dst_old,
   input  logic [SHW-1:0]         shamt,
   input  logic [SIZE_CODE_W-1:0] size,
   input  logic                   noshift,
   input  logic                   round_en,
   input  logic [1:0]             policy,
   input  logic                   upper_half,
   input  logic                   sat_clr,
   output logic                   res_valid,
   output logic [VEC_W-1:0]       result,
   output logic                   sat_flag
);

   if (NUM_SIZES < 1 || NUM_SIZES > (1 << SIZE_CODE_W)) begin : g_bad_sizes
      $error("NUM_SIZES out of range");
   end
   if (BASE_SRC_W < 2 || (BASE_SRC_W % 2) != 0) begin : g_bad_base
      $error("BASE_SRC_W must be even and at least 2");
   end
   if ((VEC_W % MAX_SRC) != 0) begin : g_bad_vec
      $error("VEC_W must be a multiple of the widest source lane");
   end

   nsh_pol_e           pol;
   logic [HALF_W-1:0]  slice_res [NUM_SIZES];
   logic [NUM_SIZES-1:0] slice_sat;
   logic [HALF_W-1:0]  packed_sel;
   logic               sat_sel;

   assign pol = nsh_pol_e'(policy);

   for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      nsh_slice #(.VEC_W(VEC_W), .SRC_W(BASE_SRC_W << s), .SHW(SHW)) u_slice (
         .src_i   (src),
         .n_i     (shamt),
         .nosh_i  (noshift),
         .rnd_i   (round_en),
         .pol_i   (pol),
         .packed_o(slice_res[s]),
         .sat_o   (slice_sat[s])
      );
   end

   always_comb begin
      packed_sel = '0;
      sat_sel    = 1'b0;
      for (int s = 0; s < NUM_SIZES; s++) begin
         if (size == SIZE_CODE_W'(s)) begin
            packed_sel = slice_res[s];
            sat_sel    = slice_sat[s];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         result    <= '0;
         sat_flag  <= 1'b0;
      end else begin
         res_valid <= op_valid;
         sat_flag  <= (sat_flag & ~sat_clr) | (op_valid & sat_sel);
         if (op_valid) begin
            if (upper_half) result <= {packed_sel, dst_old[HALF_W-1:0]};
            else            result <= {{HALF_W{1'b0}}, packed_sel};
         end
      end
   end

   a_r9_low_form_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !upper_half |=> result[VEC_W-1:HALF_W] == '0);

   a_r10_high_form_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && upper_half |=> result[HALF_W-1:0] == $past(dst_old[HALF_W-1:0]));

   a_r11_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      sat_flag && !sat_clr |=> sat_flag);

   a_r11_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      sat_clr && !op_valid |=> !sat_flag);

   a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> res_valid);

   a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(result) && !res_valid);

   a_r2_unused_size_zero: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && !upper_half && size >= SIZE_CODE_W'(NUM_SIZES) |=> result == '0);

endmodule

// File: tb/tb_nsh_narrow.sv
`timescale 1ns/1ps
module tb_nsh_narrow;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic [127:0] src = '0, dst_old = '0;
   logic [5:0]   shamt = '0;
   logic [1:0]   size = '0;
   logic         noshift = 1'b0, round_en = 1'b0, upper_half = 1'b0, sat_clr = 1'b0;
   logic [1:0]   policy = '0;
   logic         res_valid;
   logic [127:0] result;
   logic         sat_flag;

   int checks = 0, fails = 0;

   typedef struct {
      logic [127:0] res;
      bit           flag;
      string        tag;
   } exp_t;
   exp_t q[$];
   bit   mflag = 0;
   logic [127:0] last_res = '0;

   always #2.5 clk = ~clk;

   nsh_narrow dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .src(src), .dst_old(dst_old),
      .shamt(shamt), .size(size), .noshift(noshift), .round_en(round_en),
      .policy(policy), .upper_half(upper_half), .sat_clr(sat_clr),
      .res_valid(res_valid), .result(result), .sat_flag(sat_flag)
   );

   task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Independent model: shift first, then add the last bit shifted out.
   function automatic void model(input logic [127:0] s, input logic [127:0] d, input int n,
                                 input int sz, input bit nosh, input bit rnd, input int pol,
                                 input bit up, output logic [127:0] r, output bit sat);
      logic [63:0] pk;
      pk = '0;
      sat = 0;
      if (sz <= 2) begin
         int sw, dw, lanes, e;
         sw = 16 << sz; dw = sw / 2; lanes = 128 / sw;
         e = nosh ? 0 : ((n > dw) ? dw : n);
         for (int i = 0; i < lanes; i++) begin
            logic [65:0] raw, lmask;
            logic signed [65:0] v, qv, smax, smin, umax;
            logic [31:0] o;
            lmask = (66'd1 << sw) - 66'd1;
            raw = 66'(s >> (i * sw)) & lmask;
            if (pol != 2 && raw[sw-1]) raw = raw | ~lmask;
            v = raw;
            qv = v >>> e;
            if (rnd && e > 0) qv = qv + 66'(v[e-1]);
            smax = (66'sd1 <<< (dw - 1)) - 66'sd1;
            smin = -(66'sd1 <<< (dw - 1));
            umax = (66'sd1 <<< dw) - 66'sd1;
            o = qv[31:0];
            case (pol)
               1: if (qv > smax) begin o = smax[31:0]; sat = 1; end
                  else if (qv < smin) begin o = smin[31:0]; sat = 1; end
               2: if (qv > umax) begin o = umax[31:0]; sat = 1; end
               3: if (qv < 0) begin o = '0; sat = 1; end
                  else if (qv > umax) begin o = umax[31:0]; sat = 1; end
               default: ;
            endcase
            pk = pk | ((64'(o) & ((64'd1 << dw) - 64'd1)) << (i * dw));
         end
      end
      r = up ? {pk, d[63:0]} : {64'd0, pk};
   endfunction

   task automatic op(logic [127:0] s, logic [127:0] d, int n, int sz, bit nosh, bit rnd,
                     int pol, bit up, bit clr, string tag);
      exp_t e;
      bit   st;
      @(negedge clk);
      src = s; dst_old = d; shamt = 6'(n); size = 2'(sz); noshift = nosh;
      round_en = rnd; policy = 2'(pol); upper_half = up; sat_clr = clr; op_valid = 1'b1;
      model(s, d, n, sz, nosh, rnd, pol, up, e.res, st);
      mflag = (mflag & ~clr) | st;
      e.flag = mflag;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         op_valid = 1'b0; sat_clr = 1'b0;
      end
   endtask

   function automatic logic [127:0] rep16(logic [15:0] x); return {8{x}}; endfunction
   function automatic logic [127:0] rep32(logic [31:0] x); return {4{x}}; endfunction
   function automatic logic [127:0] rep64(logic [63:0] x); return {2{x}}; endfunction

   // Monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (q.size() == 0) begin
            check(0, "R12 unexpected result", result, '0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(result === e.res, e.tag, result, e.res);
            check(sat_flag === e.flag, {e.tag, " R11 flag"}, 128'(sat_flag), 128'(e.flag));
            last_res = e.res;
         end
      end
   end

   initial begin
      #(5.0 * 100000);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [127:0] mr;
      bit ms;
      repeat (3) @(negedge clk);
      check(result === '0, "R12 reset result", result, '0);
      check(sat_flag === 1'b0, "R12 reset flag", 128'(sat_flag), '0);
      check(res_valid === 1'b0, "R12 reset valid", 128'(res_valid), '0);
      rst_n = 1'b1;

      // R13 hand value: 0xCDAB >> 4 keeps 0xDA
      model(rep16(16'hCDAB), '0, 4, 0, 0, 0, 0, 0, mr, ms);
      check(mr === {64'd0, {8{8'hDA}}}, "R13 model nibble", mr, {64'd0, {8{8'hDA}}});
      op(rep16(16'hCDAB), '0, 4, 0, 0, 0, 0, 0, 0, "R13 nibble pick R1 R5");
      // R4 R7: rounding carry out of all-ones must clamp
      op(rep32(32'hFFFF_FFFF), '0, 16, 1, 0, 1, 2, 0, 0, "R4 R7 round carry clamp");
      op(rep32(32'hFFFF_FFFF), '0, 16, 1, 0, 1, 0, 0, 1, "R4 R5 round carry truncate, R11 clear");
      // R6 signed clamps both sides
      op(rep16(16'h7FFF), '0, 1, 0, 0, 1, 1, 0, 0, "R6 signed high clamp");
      op(rep16(16'h8000), '0, 1, 0, 0, 0, 1, 0, 1, "R6 signed low clamp, R11 set wins");
      op(rep16(16'h00FE), '0, 1, 0, 0, 1, 1, 0, 1, "R6 R4 in range, R11 clear");
      // R8 signed to unsigned
      op(rep64(64'h8000_0000_0000_0001), '0, 3, 2, 0, 0, 3, 0, 0, "R8 negative to zero");
      op(rep64(64'h0000_7FFF_FFFF_0000), '0, 4, 2, 0, 1, 3, 0, 1, "R8 positive clamp");
      op({64'h0000_0000_0001_2345, 64'h0000_0000_0000_8000}, '0, 16, 2, 0, 1, 3, 0, 1, "R8 R1 in range");
      // R3 shift clamp and noshift
      op(rep16(16'hA5C3), '0, 40, 0, 0, 1, 0, 0, 0, "R3 shamt above width");
      op(rep16(16'h1234), '0, 5, 0, 1, 1, 0, 0, 0, "R3 R4 noshift ignores shamt");
      op(rep16(16'h0105), '0, 5, 0, 1, 0, 2, 0, 0, "R3 R7 noshift unsigned clamp");
      // R2 unused size code
      op({128{1'b1}}, '0, 1, 3, 0, 1, 1, 0, 1, "R2 unused size");
      // R10 R9 halves
      op(rep32(32'h1357_9BDF), {64'hDEAD_BEEF_0000_1111, 64'hCAFE_F00D_1234_5678}, 8, 1, 0, 1, 0, 1, 0, "R10 high form");
      op(rep32(32'h1357_9BDF), {128{1'b1}}, 8, 1, 0, 1, 0, 0, 0, "R9 low form");
      for (int i = 0; i < 300; i++) begin
         op({$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
            int'($urandom_range(0, 40)), int'($urandom_range(0, 3)), bit'($urandom_range(0, 7) == 0),
            bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)), bit'($urandom_range(0, 1)),
            bit'($urandom_range(0, 5) == 0), "R1 R3 R4 R5 R6 R7 R8 R9 R10 random");
      end
      idle(4);
      check(result === last_res, "R12 hold when idle", result, last_res);
      check(res_valid === 1'b0, "R12 valid low when idle", 128'(res_valid), '0);
      check(q.size() == 0, "R12 all results seen", 128'(q.size()), '0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule